// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Controller

This block is the interrupt front end of one peripheral that shares a single interrupt line and a priority chain with other devices. Internal sources report pending requests, each with an enable bit. The block raises an active-low, open-drain interrupt request whenever an enabled request outranks every source already under service. It also passes or blocks the chain enable that runs from higher-priority devices to lower-priority ones.

When the CPU runs an acknowledge cycle, the block samples the acknowledge strobe on the system clock and freezes its eligible requests, so that the chain settles on a stable answer. If its chain enable input is high and it holds a frozen request, it is the winner. It then drives an interrupt vector onto the data bus while read is low, and it marks the winning source as under service. The vector can carry the index of the winning source in its low bits. A "clear highest in-service" command ends service of the top in-service source and reopens the chain.

Sources come in three kinds per channel: receive, transmit and external status. Source index i equals kind*N_CH + channel, with receive = 0, transmit = 1 and external status = 2, so a lower index always has higher priority.

Top module: `irq_chain_ctl`

## Requirements
- R1: `irq_n` is 0 in the same cycle that some bit of `src_req & src_en` has an index lower than every under-service source (any index when none is under service); otherwise it is 1.
- R2: `ieo` is 1 only when `ien` is 1, no source is under service, and no acknowledge cycle is active with a non-empty frozen set; it follows `ien` in the same cycle.
- R3: `ack_n` is sampled on the rising clock edge and an acknowledge cycle is active from the cycle after the first edge that samples it low until the cycle after an edge that samples it high. The frozen set is the eligible request set (R1) seen at the first low-sampling edge, and request changes later in the cycle do not alter the winner or the vector.
- R4: Among frozen requests the lowest index wins (receive before transmit before external status, then the lower channel).
- R5: `d_oe` is 1 exactly when an acknowledge cycle is active, `ien` is 1, the frozen set is non-empty and `rd_n` is 0, and `d_out` then carries the vector.
- R6: With `vec_mod_en` = 0 the vector equals `vec_base`. With `vec_mod_en` = 1 it is `vec_base` with its low $clog2(3*N_CH) bits (bits [2:0] by default) replaced by the winner's index.
- R7: At the first edge of a winning acknowledge cycle that samples `rd_n` low, the winner becomes under service, once per cycle. From the next cycle `ieo` is 0 and the source no longer drives `irq_n`.
- R8: A `svc_clr` pulse sampled at an edge ends service of the lowest-index under-service source only. In the next cycle the chain reopens if none remain.
- R9: After reset, nothing is under service, no acknowledge cycle is active, `irq_n` = 1 with no request, `d_oe` = 0 and `ieo` = `ien`.
- R10: An acknowledge cycle with `ien` = 0 drives no vector and puts no source under service.
- R11: While a source is under service, a request with a higher-priority index still raises `irq_n`, and requests of equal or lower priority do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 3*N_CH | Pending request per source, index = kind*N_CH + channel |
| src_en | input | 3*N_CH | Per-source enable |
| vec_base | input | DW | Base interrupt vector |
| vec_mod_en | input | 1 | Put the winner index into the low vector bits |
| svc_clr | input | 1 | Clear highest in-service source (one-cycle pulse) |
| ack_n | input | 1 | Interrupt acknowledge strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ien | input | 1 | Chain enable from the higher-priority neighbour |
| ieo | output | 1 | Chain enable to the lower-priority neighbour |
| irq_n | output | 1 | Open-drain request: 0 pulls the line low, 1 releases it |
| d_out | output | DW | Vector data, zero when not driven |
| d_oe | output | 1 | Data bus drive enable |

## Verification
`irq_n`, `ieo` and `d_oe` with `d_out` are combinational in the current inputs and state, so each is due in the same cycle as the input that moves it. Acknowledge sampling, entry into service and the clear command change state at the next rising edge, and their effect is due in the cycle after that edge. The bench drives inputs 1 ns after each rising edge and compares every output against a behavioural model at the falling edge, which puts each sample in the cycle where its result is due. The directed checks are placed at those same falling edges, one cycle after the edge that a sampled strobe needs.

// File: rtl/irq_chain_pkg.sv
// Package: shared constants for the interrupt daisy-chain controller.
// Assumes source index = kind * N_CH + channel, so index order is priority order.
package irq_chain_pkg;

    // Number of source kinds per channel.
    localparam int N_KINDS = 3;

    // Source kinds in priority order (lower value ranks higher).
    typedef enum logic [1:0] {
        KIND_RX  = 2'd0,
        KIND_TX  = 2'd1,
        KIND_EXT = 2'd2
    } src_kind_e;

    // Flat source index for a kind and a channel.
    function automatic int src_index(src_kind_e kind, int ch, int n_ch);
        return int'(kind) * n_ch + ch;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
// Module: lowest-index-wins priority picker.
// Returns the lowest set bit as one-hot and as a binary index, plus an any flag.
// Assumes IW is wide enough to hold W-1.
module irq_prio_pick #(
    parameter int W  = 6,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req,
    output logic [W-1:0]  win_oh,
    output logic [IW-1:0] win_idx,
    output logic          any
);
    localparam logic [W-1:0] ONE = W'(1);

    // Isolate the lowest set bit.
    always_comb win_oh = req & (~req + ONE);

    // Encode the lowest set bit; the last hit in a descending scan wins.
    always_comb begin
        win_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IW'(i);
        end
    end

    // Flag any request.
    always_comb any = |req;

endmodule

// File: rtl/irq_svc_track.sv
// Module: under-service tracker.
// Holds one in-service bit per source, sets the acknowledged winner, clears the
// highest-priority in-service bit on command, and produces the mask of sources
// that outrank everything in service. Assumes set_oh is one-hot or zero.
module irq_svc_track #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_oh,
    input  logic         clr,
    output logic [W-1:0] outrank,
    output logic         any_svc
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] svc_q;
    logic [W-1:0] top_oh;

    // Highest-priority in-service source, one-hot.
    always_comb top_oh = svc_q & (~svc_q + ONE);

    // Bits strictly below the top in-service bit; all ones when none in service.
    always_comb outrank = top_oh - ONE;

    // Any source in service.
    always_comb any_svc = |svc_q;

    // In-service register: clear the top bit on command, then add the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else begin
            svc_q <= (svc_q & ~(clr ? top_oh : '0)) | set_oh;
        end
    end

    // R7: at most one source enters service per edge.
    a_r7_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_oh));

    // R8: a lone clear removes exactly one in-service bit.
    a_r8_clear_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_oh == '0 && svc_q != '0)
        |=> ($countones(svc_q) == $past($countones(svc_q)) - 1));

endmodule

// File: rtl/irq_ack_ctl.sv
// Module: acknowledge cycle control.
// Samples the acknowledge strobe on the clock, freezes eligible requests at the
// start of the cycle, and emits a one-shot take strobe when this device wins
// and read is low. Assumes ack_n and rd_n are already synchronous to clk.
module irq_ack_ctl #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_n,
    input  logic         rd_n,
    input  logic         ien,
    input  logic [W-1:0] elig,
    output logic         ack_act,
    output logic [W-1:0] frz,
    output logic         take
);
    logic taken_q;

    // Winner takes service once, on the first read-low edge of the cycle.
    always_comb take = ack_act & ien & (|frz) & ~rd_n & ~taken_q;

    // Acknowledge state: enter and freeze on first low sample, leave on high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_act <= 1'b0;
            frz     <= '0;
            taken_q <= 1'b0;
        end else if (ack_n) begin
            ack_act <= 1'b0;
            frz     <= '0;
            taken_q <= 1'b0;
        end else begin
            if (!ack_act) begin
                ack_act <= 1'b1;
                frz     <= elig;
            end
            if (take) taken_q <= 1'b1;
        end
    end

    // R3: the frozen set holds for the whole acknowledge cycle.
    a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_act && $past(ack_act)) |-> $stable(frz));

    // R7: the take strobe never fires on two consecutive edges.
    a_r7_take_once: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

endmodule

// File: rtl/irq_vec_fmt.sv
// Module: vector formatter.
// Optionally replaces the low bits of the base vector with the winner index.
// A generate branch covers an index as wide as the vector or wider.
module irq_vec_fmt #(
    parameter int DW = 8,
    parameter int IW = 3
) (
    input  logic [DW-1:0] base,
    input  logic          mod_en,
    input  logic [IW-1:0] idx,
    output logic [DW-1:0] vec
);
    if (IW < DW) begin : g_merge
        // Keep the upper base bits, put the index in the low bits.
        always_comb vec = mod_en ? {base[DW-1:IW], idx} : base;
    end else begin : g_full
        // Index fills the vector completely.
        always_comb vec = mod_en ? idx[DW-1:0] : base;
    end

endmodule

// File: rtl/irq_chain_ctl.sv
// Module: interrupt daisy-chain controller (top).
// Gathers enabled requests, masks those not outranking an in-service source,
// drives the open-drain request, gates the chain enable, and answers the
// acknowledge cycle with a vector. Assumes ack_n, rd_n and ien are synchronous.
module irq_chain_ctl #(
    parameter int N_CH = 2,
    parameter int DW   = 8,
    localparam int N_SRC = irq_chain_pkg::N_KINDS * N_CH,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic [DW-1:0]    vec_base,
    input  logic             vec_mod_en,
    input  logic             svc_clr,
    input  logic             ack_n,
    input  logic             rd_n,
    input  logic             ien,
    output logic             ieo,
    output logic             irq_n,
    output logic [DW-1:0]    d_out,
    output logic             d_oe
);
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] elig;
    logic [N_SRC-1:0] outrank;
    logic             any_svc;
    logic             ack_act;
    logic [N_SRC-1:0] frz;
    logic             take;
    logic [N_SRC-1:0] win_oh;
    logic [IDX_W-1:0] win_idx;
    logic             frz_any;
    logic [DW-1:0]    vec;

    // Enabled requests, then only those outranking every in-service source.
    always_comb pend = src_req & src_en;
    always_comb elig = pend & outrank;

    irq_svc_track #(.W(N_SRC)) u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_oh  (take ? win_oh : '0),
        .clr     (svc_clr),
        .outrank (outrank),
        .any_svc (any_svc)
    );

    irq_ack_ctl #(.W(N_SRC)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_n   (ack_n),
        .rd_n    (rd_n),
        .ien     (ien),
        .elig    (elig),
        .ack_act (ack_act),
        .frz     (frz),
        .take    (take)
    );

    irq_prio_pick #(.W(N_SRC), .IW(IDX_W)) u_pick (
        .req     (frz),
        .win_oh  (win_oh),
        .win_idx (win_idx),
        .any     (frz_any)
    );

    irq_vec_fmt #(.DW(DW), .IW(IDX_W)) u_vec (
        .base   (vec_base),
        .mod_en (vec_mod_en),
        .idx    (win_idx),
        .vec    (vec)
    );

    // Open-drain request: pull low while any eligible request exists.
    always_comb irq_n = ~|elig;

    // Chain pass-through: blocked while in service or holding a frozen request.
    always_comb ieo = ien & ~any_svc & ~(ack_act & frz_any);

    // Vector drive while this device wins the acknowledge cycle and read is low.
    always_comb d_oe = ack_act & ien & frz_any & ~rd_n;
    always_comb d_out = d_oe ? vec : '0;

    // R2: a low chain input always blocks the chain output.
    a_r2_ieo_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !ieo);

    // R5: a device driving its vector holds the chain closed.
    a_r5_owner_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> !ieo);

    // R1: an enabled request with nothing in service raises the interrupt.
    a_r1_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0 && !any_svc) |-> !irq_n);

    // R7: a source that enters service closes the chain on the next cycle.
    a_r7_service_closes_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !svc_clr) |=> !ieo);

endmodule

// File: tb/irq_chain_ctl_tb_top.sv
// Bench: directed scenarios plus random traffic, every cycle compared against a
// behavioural model kept in plain bit vectors and integer loops.
module irq_chain_ctl_tb_top;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic [NS-1:0] src_en = '1;
    logic [7:0]    vec_base = 8'hA5;
    logic          vec_mod_en = 1'b1;
    logic          svc_clr = 1'b0;
    logic          ack_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          ien = 1'b1;
    logic          ieo;
    logic          irq_n;
    logic [7:0]    d_out;
    logic          d_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Model state.
    logic [NS-1:0] m_svc = '0;
    logic [NS-1:0] m_frz = '0;
    bit            m_ack = 1'b0;
    bit            m_taken = 1'b0;

    irq_chain_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .vec_base(vec_base), .vec_mod_en(vec_mod_en), .svc_clr(svc_clr),
        .ack_n(ack_n), .rd_n(rd_n), .ien(ien), .ieo(ieo), .irq_n(irq_n),
        .d_out(d_out), .d_oe(d_oe)
    );

    always #2 clk = ~clk;

    function automatic int lowest(logic [NS-1:0] v);
        for (int i = 0; i < NS; i++) if (v[i]) return i;
        return NS;
    endfunction

    function automatic logic [NS-1:0] m_elig();
        logic [NS-1:0] r;
        int top;
        top = lowest(m_svc);
        r = '0;
        for (int i = 0; i < NS; i++) r[i] = src_req[i] & src_en[i] & (i < top);
        return r;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge, from the values present before it.
    always @(posedge clk) begin
        logic [NS-1:0] el, nsvc;
        int top, win;
        if (!rst_n) begin
            m_svc = '0; m_frz = '0; m_ack = 0; m_taken = 0;
        end else begin
            el   = m_elig();
            top  = lowest(m_svc);
            win  = lowest(m_frz);
            nsvc = m_svc;
            if (svc_clr && top < NS) nsvc[top] = 1'b0;
            if (m_ack && ien && win < NS && !rd_n && !m_taken) begin
                nsvc[win] = 1'b1;
                m_taken = 1;
            end
            m_svc = nsvc;
            if (ack_n) begin
                m_ack = 0; m_frz = '0; m_taken = 0;
            end else if (!m_ack) begin
                m_ack = 1; m_frz = el;
            end
        end
    end

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        int win;
        bit e_irq, e_ieo, e_oe;
        logic [7:0] e_vec;
        if (cmp_on) begin
            win   = lowest(m_frz);
            e_irq = (m_elig() == '0);
            e_ieo = ien && (m_svc == '0) && !(m_ack && win < NS);
            e_oe  = m_ack && ien && win < NS && !rd_n;
            e_vec = vec_mod_en ? {vec_base[7:3], 3'(win)} : vec_base;
            check(irq_n === e_irq, "R1 irq_n", irq_n, e_irq);
            check(ieo === e_ieo, "R2 ieo", ieo, e_ieo);
            check(d_oe === e_oe, "R5 d_oe", d_oe, e_oe);
            if (e_oe) check(d_out === e_vec, "R6 d_out", d_out, e_vec);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic print_summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            print_summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        cmp_on = 1'b1;
        settle();
        check(irq_n == 1 && d_oe == 0 && ieo == 1, "R9 reset state",
              {irq_n, d_oe, ieo}, 3'b101);

        // R1: one enabled request, then masked.
        tick(); src_req = 6'b010000;
        settle(); check(irq_n == 0, "R1 enabled request", irq_n, 0);
        tick(); src_en = 6'b101111;
        settle(); check(irq_n == 1, "R1 masked request", irq_n, 1);
        tick(); src_en = '1;

        // R3/R4/R6/R7/R11: acknowledge with two requests, late arrival ignored.
        tick(); src_req = 6'b011000; ack_n = 0;
        settle(); check(ieo == 1, "R3 ack not yet sampled", ieo, 1);
        tick(); src_req = 6'b011001;
        settle(); check(ieo == 0, "R2 chain closed in ack", ieo, 0);
        tick(); rd_n = 0;
        settle(); check(d_oe == 1 && d_out == 8'hA3, "R4 winner index 3 vector",
                        d_out, 8'hA3);
        check(d_out != 8'hA0, "R3 late request ignored", d_out, 8'hA3);
        tick(); rd_n = 1; ack_n = 1;
        tick();
        settle(); check(ieo == 0, "R7 in service closes chain", ieo, 0);
        check(irq_n == 0, "R11 higher request interrupts", irq_n, 0);
        tick(); src_req = 6'b011000;
        settle(); check(irq_n == 1, "R11 lower request blocked", irq_n, 1);
        tick(); svc_clr = 1;
        tick(); svc_clr = 0;
        settle(); check(ieo == 1, "R8 chain reopens", ieo, 1);
        check(irq_n == 0, "R8 requests eligible again", irq_n, 0);

        // R6: unmodified vector.
        tick(); src_req = 6'b000100; vec_mod_en = 0; ack_n = 0;
        tick(); rd_n = 0;
        settle(); check(d_out == 8'hA5, "R6 base vector", d_out, 8'hA5);
        tick(); rd_n = 1; ack_n = 1;
        tick(); svc_clr = 1;
        tick(); svc_clr = 0; vec_mod_en = 1;

        // R10: acknowledge with the chain input low.
        tick(); ien = 0; src_req = 6'b000010; ack_n = 0;
        tick(); rd_n = 0;
        settle(); check(d_oe == 0, "R10 no vector when blocked", d_oe, 0);
        tick(); rd_n = 1; ack_n = 1;
        tick(); ien = 1;
        settle(); check(ieo == 1, "R10 nothing taken into service", ieo, 1);

        // R8/R11: nested service, clear removes the higher one.
        tick(); src_req = 6'b100000; ack_n = 0;
        tick(); rd_n = 0;
        tick(); rd_n = 1; ack_n = 1;
        tick(); src_req = 6'b100010;
        settle(); check(irq_n == 0, "R11 nested higher request", irq_n, 0);
        ack_n = 0;
        tick(); rd_n = 0;
        settle(); check(d_out == 8'hA1, "R4 nested winner", d_out, 8'hA1);
        tick(); rd_n = 1; ack_n = 1; src_req = 6'b010000;
        tick(); svc_clr = 1;
        tick(); svc_clr = 0;
        settle(); check(irq_n == 0, "R8 clear takes the higher one", irq_n, 0);
        check(ieo == 0, "R8 lower still in service", ieo, 0);
        tick(); svc_clr = 1;
        tick(); svc_clr = 0;
        settle(); check(ieo == 1, "R8 all cleared", ieo, 1);

        // Random traffic, checked by the model every cycle.
        for (int k = 0; k < 600; k++) begin
            tick();
            src_req    = 6'($urandom);
            src_en     = ($urandom % 4 == 0) ? 6'($urandom) : '1;
            ien        = ($urandom % 8) != 0;
            svc_clr    = ($urandom % 6) == 0;
            vec_mod_en = 1'($urandom);
            vec_base   = 8'($urandom);
            if (ack_n) ack_n = ($urandom % 6) != 0;
            else       ack_n = ($urandom % 4) == 0;
            rd_n       = ack_n ? 1'b1 : 1'($urandom);
        end
        tick(); ack_n = 1; rd_n = 1; svc_clr = 0;
        repeat (4) tick();

        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule